// File: doc/BRIEF.md
# Exception entry and return controller

This block holds the trap state of a small RISC core. It tracks two level flags: the error level, raised by reset-class and non-maskable events, and the exception level, raised by every other exception or interrupt. It keeps one saved return address for each level. It also tracks the number of the active shadow register set and the number of the set that was active before the trap. The pipeline reports trap events with the faulting PC. The block stores what it needs and sets the matching flag.

When the pipeline issues the return-from-exception command, the block chooses one saved address according to the flags. The error level wins over the exception level. The block clears that one flag and restores the previous set number into the current one. In the next cycle it emits a fetch redirect with bit 0 of the address cleared. Software may rewrite either saved address before the return, and may load the current set number directly.

Top module: `trap_ctrl`

## Requirements
- R1: After reset both level flags are 0, both set numbers are 0 and the redirect strobe is 0.
- R2: A cycle with `crit_req` high sets the error flag and captures `fault_pc` as the error return address. This happens even when a level flag is already set, and the exception flag is left as it was.
- R3: A cycle with `gen_req` high sets the exception flag and captures `fault_pc` as the exception return address, but only when both flags are 0 and `crit_req` is low. In any other case the request changes neither flag, neither address and not the previous set number.
- R4: An accepted return while the error flag is 1 clears only the error flag and redirects to the error return address with bit 0 forced to 0. This applies even when the exception flag is also 1.
- R5: An accepted return while the error flag is 0 and the exception flag is 1 clears the exception flag and redirects to the exception return address with bit 0 forced to 0.
- R6: A return command while both flags are 0 produces no strobe and changes no flag, set number or redirect address.
- R7: `redir_vld` is high for exactly the one cycle after each accepted return, and `redir_pc` holds its value between redirects.
- R8: Trap entry taken while both flags are 0 and `shadow_dis` is 0 copies the current set number into the previous one and leaves the current number unchanged. With `shadow_dis` at 1 the previous number is not changed.
- R9: An accepted return copies the previous set number into the current one.
- R10: `err_pc_wr` and `exc_pc_wr` load `pc_wdata` into the error and exception return addresses. A later return resumes at the written value. A hardware capture in the same cycle takes precedence over the write.
- R11: A return command in a cycle where a trap entry is accepted is ignored.
- R12: `set_wr` loads `set_wdata` into the current set number, and a return accepted in the same cycle takes precedence over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| crit_req | input | 1 | Reset/NMI-class trap event |
| gen_req | input | 1 | General exception or interrupt event |
| fault_pc | input | 32 | PC of the interrupted instruction |
| eret_cmd | input | 1 | Return-from-exception command |
| shadow_dis | input | 1 | 1 disables shadow set tracking on entry |
| set_wr | input | 1 | Load the current set number |
| set_wdata | input | 4 | Value for the current set number |
| err_pc_wr | input | 1 | Software write of the error return address |
| exc_pc_wr | input | 1 | Software write of the exception return address |
| pc_wdata | input | 32 | Data for software address writes |
| redir_pc | output | 32 | Fetch redirect target |
| redir_vld | output | 1 | One-cycle redirect strobe |
| erl | output | 1 | Error level flag |
| exl | output | 1 | Exception level flag |
| cur_set | output | 4 | Active shadow set number |
| prev_set | output | 4 | Set number saved at trap entry |

## Verification
The hardest state to reach is the one where both flags are set. The return must use the error address and leave the exception address untouched for a second return. To reach it, the stimulus first takes a general exception, then changes the current set number, then raises a critical event. The bench checks that the first return takes the error address, clears only the error flag and restores the set saved at the first entry. It then checks that a second return, in the very next cycle, reaches the original exception address. Same-cycle collisions are driven directly: entry against return, capture against software write, and return against set load.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int unsigned PC_W  = 32;
    localparam int unsigned SET_W = 4;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [SET_W-1:0] set_t;

    typedef struct packed {
        logic erl;
        logic exl;
    } lvl_s;

    typedef struct packed {
        pc_t  err_pc;
        pc_t  exc_pc;
        pc_t  tgt;
        logic vld;
    } pcs_s;

    typedef struct packed {
        set_t cur;
        set_t prev;
    } sets_s;
endpackage

// File: rtl/trap_level.sv
module trap_level
    import trap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic crit_req,
    input  logic gen_req,
    input  logic eret_cmd,
    output logic erl,
    output logic exl,
    output logic take_crit,
    output logic take_gen,
    output logic fresh_entry,
    output logic ret_err,
    output logic ret_exc
);
    lvl_s lvl_d, lvl_q;
    logic in_level;
    logic ret_any;

    always_comb begin
        in_level    = lvl_q.erl | lvl_q.exl;
        take_crit   = crit_req;
        take_gen    = gen_req & ~crit_req & ~in_level;
        fresh_entry = (crit_req | gen_req) & ~in_level;
        ret_any     = eret_cmd & ~take_crit & ~take_gen & in_level;
        ret_err     = ret_any & lvl_q.erl;
        ret_exc     = ret_any & ~lvl_q.erl;

        lvl_d = lvl_q;
        if (take_crit)    lvl_d.erl = 1'b1;
        else if (ret_err) lvl_d.erl = 1'b0;
        if (take_gen)     lvl_d.exl = 1'b1;
        else if (ret_exc) lvl_d.exl = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign erl = lvl_q.erl;
    assign exl = lvl_q.exl;

    p_crit_sets_erl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        crit_req |=> lvl_q.erl);
    p_gen_sets_exl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req && !crit_req && !lvl_q.erl && !lvl_q.exl) |=> lvl_q.exl);
    p_err_ret_keeps_exl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_cmd && lvl_q.erl && !crit_req) |=> (!lvl_q.erl && lvl_q.exl == $past(lvl_q.exl)));
    p_idle_ret_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_cmd && !lvl_q.erl && !lvl_q.exl && !crit_req && !gen_req) |=> (!lvl_q.erl && !lvl_q.exl));
endmodule

// File: rtl/trap_pc_store.sv
module trap_pc_store
    import trap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_crit,
    input  logic take_gen,
    input  logic ret_err,
    input  logic ret_exc,
    input  pc_t  fault_pc,
    input  logic err_pc_wr,
    input  logic exc_pc_wr,
    input  pc_t  pc_wdata,
    output pc_t  redir_pc,
    output logic redir_vld
);
    localparam pc_t EVEN_MASK = ~pc_t'(1);

    pcs_s pcs_d, pcs_q;

    always_comb begin
        pcs_d     = pcs_q;
        pcs_d.vld = ret_err | ret_exc;

        if (take_crit)      pcs_d.err_pc = fault_pc;
        else if (err_pc_wr) pcs_d.err_pc = pc_wdata;

        if (take_gen)       pcs_d.exc_pc = fault_pc;
        else if (exc_pc_wr) pcs_d.exc_pc = pc_wdata;

        if (ret_err)        pcs_d.tgt = pcs_q.err_pc & EVEN_MASK;
        else if (ret_exc)   pcs_d.tgt = pcs_q.exc_pc & EVEN_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcs_q <= '0;
        else        pcs_q <= pcs_d;
    end

    assign redir_pc  = pcs_q.tgt;
    assign redir_vld = pcs_q.vld;

    p_redirect_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld |-> (redir_pc[0] == 1'b0));
    p_epc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_gen && !exc_pc_wr) |=> $stable(pcs_q.exc_pc));
    p_target_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_err && !ret_exc) |=> ($stable(redir_pc) && !redir_vld));
endmodule

// File: rtl/trap_set_track.sv
module trap_set_track
    import trap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fresh_entry,
    input  logic shadow_dis,
    input  logic ret_any,
    input  logic set_wr,
    input  set_t set_wdata,
    output set_t cur_set,
    output set_t prev_set
);
    sets_s sets_d, sets_q;

    always_comb begin
        sets_d = sets_q;
        if (fresh_entry && !shadow_dis) sets_d.prev = sets_q.cur;
        if (ret_any)                    sets_d.cur  = sets_q.prev;
        else if (set_wr)                sets_d.cur  = set_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sets_q <= '0;
        else        sets_q <= sets_d;
    end

    assign cur_set  = sets_q.cur;
    assign prev_set = sets_q.prev;

    p_entry_keeps_cur_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh_entry && !set_wr) |=> $stable(sets_q.cur));
    p_ssd_keeps_prev_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_dis |=> $stable(sets_q.prev));
    p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_any |=> (sets_q.cur == $past(sets_q.prev)));
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        crit_req,
    input  logic        gen_req,
    input  logic [31:0] fault_pc,
    input  logic        eret_cmd,
    input  logic        shadow_dis,
    input  logic        set_wr,
    input  logic [3:0]  set_wdata,
    input  logic        err_pc_wr,
    input  logic        exc_pc_wr,
    input  logic [31:0] pc_wdata,
    output logic [31:0] redir_pc,
    output logic        redir_vld,
    output logic        erl,
    output logic        exl,
    output logic [3:0]  cur_set,
    output logic [3:0]  prev_set
);
    logic take_crit, take_gen, fresh_entry, ret_err, ret_exc;

    trap_level u_level (
        .clk         (clk),
        .rst_n       (rst_n),
        .crit_req    (crit_req),
        .gen_req     (gen_req),
        .eret_cmd    (eret_cmd),
        .erl         (erl),
        .exl         (exl),
        .take_crit   (take_crit),
        .take_gen    (take_gen),
        .fresh_entry (fresh_entry),
        .ret_err     (ret_err),
        .ret_exc     (ret_exc)
    );

    trap_pc_store u_pcs (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_crit (take_crit),
        .take_gen  (take_gen),
        .ret_err   (ret_err),
        .ret_exc   (ret_exc),
        .fault_pc  (fault_pc),
        .err_pc_wr (err_pc_wr),
        .exc_pc_wr (exc_pc_wr),
        .pc_wdata  (pc_wdata),
        .redir_pc  (redir_pc),
        .redir_vld (redir_vld)
    );

    trap_set_track u_sets (
        .clk         (clk),
        .rst_n       (rst_n),
        .fresh_entry (fresh_entry),
        .shadow_dis  (shadow_dis),
        .ret_any     (ret_err | ret_exc),
        .set_wr      (set_wr),
        .set_wdata   (set_wdata),
        .cur_set     (cur_set),
        .prev_set    (prev_set)
    );

    p_entry_blocks_ret_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_cmd && crit_req) |=> !redir_vld);
endmodule

// File: tb/trap_ctrl_tb.sv
module trap_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crit_req = 1'b0, gen_req = 1'b0, eret_cmd = 1'b0;
    logic        shadow_dis = 1'b0, set_wr = 1'b0;
    logic        err_pc_wr = 1'b0, exc_pc_wr = 1'b0;
    logic [31:0] fault_pc = '0, pc_wdata = '0;
    logic [3:0]  set_wdata = '0;
    logic [31:0] redir_pc;
    logic        redir_vld, erl, exl;
    logic [3:0]  cur_set, prev_set;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .crit_req(crit_req), .gen_req(gen_req),
        .fault_pc(fault_pc), .eret_cmd(eret_cmd), .shadow_dis(shadow_dis),
        .set_wr(set_wr), .set_wdata(set_wdata), .err_pc_wr(err_pc_wr),
        .exc_pc_wr(exc_pc_wr), .pc_wdata(pc_wdata), .redir_pc(redir_pc),
        .redir_vld(redir_vld), .erl(erl), .exl(exl), .cur_set(cur_set),
        .prev_set(prev_set)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        crit_req = 0; gen_req = 0; eret_cmd = 0; set_wr = 0;
        err_pc_wr = 0; exc_pc_wr = 0; shadow_dis = 0;
    endtask

    task automatic load_set(input logic [3:0] v);
        set_wr = 1; set_wdata = v; tick(); set_wr = 0;
    endtask

    task automatic gen(input logic [31:0] pc);
        gen_req = 1; fault_pc = pc; tick(); gen_req = 0;
    endtask

    task automatic crit(input logic [31:0] pc);
        crit_req = 1; fault_pc = pc; tick(); crit_req = 0;
    endtask

    task automatic eret();
        eret_cmd = 1; tick(); eret_cmd = 0;
    endtask

    task automatic t_reset();
        chk("R1 erl", erl, 0);
        chk("R1 exl", exl, 0);
        chk("R1 cur_set", cur_set, 0);
        chk("R1 prev_set", prev_set, 0);
        chk("R1 redir_vld", redir_vld, 0);
    endtask

    task automatic t_general();
        load_set(4'd5);
        chk("R12 set load", cur_set, 5);
        gen(32'h1000_0040);
        chk("R3 exl set", exl, 1);
        chk("R3 erl clear", erl, 0);
        chk("R8 prev copy", prev_set, 5);
        chk("R8 cur kept", cur_set, 5);
        load_set(4'd11);
        eret();
        chk("R5 exl cleared", exl, 0);
        chk("R7 strobe", redir_vld, 1);
        chk("R5 target", redir_pc, 32'h1000_0040);
        chk("R9 restore", cur_set, 5);
        tick();
        chk("R7 strobe falls", redir_vld, 0);
        chk("R7 target held", redir_pc, 32'h1000_0040);
    endtask

    task automatic t_nested_general();
        load_set(4'd3);
        gen(32'h0000_0A00);
        load_set(4'd7);
        gen(32'h0000_0B00);
        chk("R3 ignored keeps prev", prev_set, 3);
        chk("R3 ignored keeps exl", exl, 1);
        eret();
        chk("R3 ignored keeps EPC", redir_pc, 32'h0000_0A00);
        chk("R9 restore nested", cur_set, 3);
        tick();
    endtask

    task automatic t_both_levels();
        load_set(4'd2);
        gen(32'h0000_0200);
        load_set(4'd9);
        crit(32'h0000_0301);
        chk("R2 erl set", erl, 1);
        chk("R2 exl kept", exl, 1);
        chk("R3 prev not on nested crit", prev_set, 2);
        eret_cmd = 1; tick();
        chk("R4 err target bit0 clear", redir_pc, 32'h0000_0300);
        chk("R4 only erl cleared", {30'd0, erl, exl}, 32'h1);
        chk("R9 restore from both", cur_set, 2);
        tick(); eret_cmd = 0;
        chk("R7 back-to-back strobe", redir_vld, 1);
        chk("R5 epc after erl", redir_pc, 32'h0000_0200);
        chk("R5 exl cleared", exl, 0);
        tick();
    endtask

    task automatic t_idle_return();
        load_set(4'd6);
        eret();
        chk("R6 no strobe", redir_vld, 0);
        chk("R6 target held", redir_pc, 32'h0000_0200);
        chk("R6 cur unchanged", cur_set, 6);
        chk("R6 flags", {30'd0, erl, exl}, 0);
    endtask

    task automatic t_shadow_disable();
        load_set(4'd6);
        gen(32'h40);
        eret();
        chk("R9 cur back", cur_set, 6);
        tick();
        shadow_dis = 1;
        load_set(4'd4);
        gen(32'h44);
        chk("R8 ssd keeps prev", prev_set, 6);
        chk("R8 ssd keeps cur", cur_set, 4);
        shadow_dis = 0;
        eret();
        chk("R9 restore after ssd", cur_set, 6);
        tick();
    endtask

    task automatic t_sw_write();
        crit(32'h0000_0400);
        err_pc_wr = 1; pc_wdata = 32'h0000_0889; tick(); err_pc_wr = 0;
        eret();
        chk("R10 err write used", redir_pc, 32'h0000_0888);
        tick();
        gen_req = 1; fault_pc = 32'h0000_0500;
        exc_pc_wr = 1; pc_wdata = 32'h0000_0999;
        tick(); gen_req = 0; exc_pc_wr = 0;
        eret();
        chk("R10 capture beats write", redir_pc, 32'h0000_0500);
        tick();
    endtask

    task automatic t_collisions();
        crit_req = 1; gen_req = 1; fault_pc = 32'h0000_0600;
        tick(); crit_req = 0; gen_req = 0;
        chk("R3 crit wins", {30'd0, erl, exl}, 32'h2);
        crit_req = 1; eret_cmd = 1; fault_pc = 32'h0000_0700;
        tick(); crit_req = 0; eret_cmd = 0;
        chk("R11 eret ignored", redir_vld, 0);
        chk("R11 erl stays", erl, 1);
        load_set(4'd1);
        eret_cmd = 1; set_wr = 1; set_wdata = 4'd12;
        tick(); eret_cmd = 0; set_wr = 0;
        chk("R2 new capture used", redir_pc, 32'h0000_0700);
        chk("R12 restore beats load", cur_set, prev_set);
        tick();
    endtask

    initial begin
        clear_in();
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_general();
        t_nested_general();
        t_both_levels();
        t_idle_return();
        t_shadow_disable();
        t_sw_write();
        t_collisions();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule